// File: doc/BRIEF.md
# Segment Bound and Translation-Path Checker

This block judges a single linear memory access against the segment it belongs to, and it decides where the access goes next. It takes the access address, byte count and kind (data read, data write or instruction fetch), and the segment's base, limit and three attribute bits. It also takes four mode bits: protection on, paging on, long mode active, and code segment 64-bit. It produces three results. The first is a protection fault. The second is a request for a page-table lookup. The third is a physical address that is valid when the access bypasses paging.

The checker is purely combinational and is meant to sit in the address-generation stage of a load/store or fetch pipe. All comparisons are unsigned. The end address (address plus size) is formed one bit wider than the address, so a sum that runs past the top of the address space is seen as large rather than wrapping to a small value. Both expand-up and expand-down segments handle a limit that lies below the base. A fault always suppresses the lookup request and forces the physical address to zero.

Top module: `segLimitChecker`

## Requirements
- R1: With `protEn` low, `protFault` and `needLookup` are 0 and `physAddr` equals `linAddr`, whatever the other inputs are.
- R2: With `protEn` high and both `longAct` and `codeLong64` high, no segment check is made, so `protFault` is 0.
- R3: With segment checks active, a write (`accWrite`=1) to a segment with `segWritable`=0 faults.
- R4: With segment checks active, a plain read (`accWrite`=0, `accFetch`=0) to a segment with `segReadable`=0 faults; a fetch does not fault for that reason.
- R5: With `segExpDown`=0 and `segLimit` >= `segBase`, the access faults exactly when `linAddr`+`accSize` (carry kept) > `segLimit`.
- R6: With `segExpDown`=0 and `segLimit` < `segBase`, the access faults exactly when `linAddr`+`accSize` > `segLimit` and `linAddr` < `segBase`.
- R7: With `segExpDown`=1 and `segLimit` >= `segBase`, the access faults exactly when `linAddr` <= `segLimit` and `linAddr`+`accSize` >= `segBase`.
- R8: With `segExpDown`=1 and `segLimit` < `segBase`, the access faults exactly when `linAddr` <= `segLimit` or `linAddr`+`accSize` >= `segBase`.
- R9: With `protEn` high, `pageEn` high and no fault, `needLookup` is 1 and `physAddr` is 0.
- R10: With `protEn` high, `pageEn` low and no fault, `needLookup` is 0 and `physAddr` equals `linAddr`.
- R11: Whenever `protFault` is 1, `needLookup` is 0 and `physAddr` is 0.
- R12: When only one of `longAct` and `codeLong64` is high, the segment checks stay active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| linAddr | input | ADDR_W | Linear address of the access |
| accSize | input | SIZE_W | Access byte count |
| accWrite | input | 1 | Access is a write |
| accFetch | input | 1 | Access is an instruction fetch |
| segBase | input | ADDR_W | Segment base |
| segLimit | input | ADDR_W | Segment limit |
| segReadable | input | 1 | Segment allows data reads |
| segWritable | input | 1 | Segment allows writes |
| segExpDown | input | 1 | Segment grows downward |
| protEn | input | 1 | Protection enabled |
| pageEn | input | 1 | Paging enabled |
| longAct | input | 1 | Long mode active |
| codeLong64 | input | 1 | Code segment runs in 64-bit mode |
| protFault | output | 1 | Protection fault |
| needLookup | output | 1 | Access needs a page-table lookup |
| physAddr | output | ADDR_W | Pass-through physical address, 0 otherwise |

## Verification
The bench uses a 5-bit address and a 2-bit size. It sweeps every base, limit, address and size for both segment directions. This covers the split between the plain and wrapped bound rules, the cases where the limit equals the base, and end addresses that carry past the top of the address space. A second sweep visits every combination of the mode bits, access kind and attribute bits over a handful of address triples. That sweep separates real mode, full long mode and half-set long mode. It also shows that a write and a plain read are judged against different attribute bits, and that the fault masks the lookup request and the pass-through address.

// File: rtl/segChkPkg.sv
package segChkPkg;
  // Strobes from the mode/rights decoder to the address datapath.
  typedef struct packed {
    logic checkEn;     // segment checks apply
    logic rightsFault; // attribute violation, already gated by checkEn
    logic expandDown;  // bound rule variant
    logic pagingOn;    // protected mode with paging
  } segStrobes_t;
endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segChkPkg::*;
(
  input  logic        accWrite,
  input  logic        accFetch,
  input  logic        segReadable,
  input  logic        segWritable,
  input  logic        segExpDown,
  input  logic        protEn,
  input  logic        pageEn,
  input  logic        longAct,
  input  logic        codeLong64,
  output segStrobes_t strb
);
  logic fullLong;
  logic plainRead;
  logic wrDenied;
  logic rdDenied;

  always_comb begin
    fullLong  = longAct & codeLong64;
    plainRead = ~accWrite & ~accFetch;
    wrDenied  = accWrite & ~segWritable;
    rdDenied  = plainRead & ~segReadable;

    strb.checkEn     = protEn & ~fullLong;
    strb.rightsFault = protEn & ~fullLong & (wrDenied | rdDenied);
    strb.expandDown  = segExpDown;
    strb.pagingOn    = protEn & pageEn;
  end
endmodule

// File: rtl/segBoundCmp.sv
module segBoundCmp #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] linAddr,
  input  logic [SIZE_W-1:0] accSize,
  input  logic [ADDR_W-1:0] segBase,
  input  logic [ADDR_W-1:0] segLimit,
  input  logic              expandDown,
  output logic              boundFault
);
  localparam int SUM_W = ADDR_W + 1;
  localparam int PAD_W = SUM_W - SIZE_W;

  logic [SUM_W-1:0] endAddr;
  logic [SUM_W-1:0] limitExt;
  logic [SUM_W-1:0] baseExt;
  logic             wrapped;
  logic             pastLimit;
  logic             belowBase;
  logic             atOrUnderLimit;
  logic             reachesBase;
  logic             upFault;
  logic             downFault;

  always_comb begin
    endAddr  = {1'b0, linAddr} + {{PAD_W{1'b0}}, accSize};
    limitExt = {1'b0, segLimit};
    baseExt  = {1'b0, segBase};
    wrapped  = segLimit < segBase;

    pastLimit      = endAddr > limitExt;
    belowBase      = linAddr < segBase;
    atOrUnderLimit = linAddr <= segLimit;
    reachesBase    = endAddr >= baseExt;

    upFault   = wrapped ? (pastLimit & belowBase) : pastLimit;
    downFault = wrapped ? (atOrUnderLimit | reachesBase)
                        : (atOrUnderLimit & reachesBase);
    boundFault = expandDown ? downFault : upFault;
  end
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segChkPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] linAddr,
  input  logic [SIZE_W-1:0] accSize,
  input  logic [ADDR_W-1:0] segBase,
  input  logic [ADDR_W-1:0] segLimit,
  input  segStrobes_t       strb,
  output logic              protFault,
  output logic              needLookup,
  output logic [ADDR_W-1:0] physAddr
);
  logic boundFault;
  logic passThru;

  segBoundCmp #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) bound_i (
    .linAddr   (linAddr),
    .accSize   (accSize),
    .segBase   (segBase),
    .segLimit  (segLimit),
    .expandDown(strb.expandDown),
    .boundFault(boundFault)
  );

  always_comb begin
    protFault  = strb.rightsFault | (strb.checkEn & boundFault);
    needLookup = strb.pagingOn & ~protFault;
    passThru   = ~strb.pagingOn & ~protFault;
    physAddr   = passThru ? linAddr : '0;
  end
endmodule

// File: rtl/segLimitChecker.sv
module segLimitChecker
  import segChkPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] linAddr,
  input  logic [SIZE_W-1:0] accSize,
  input  logic              accWrite,
  input  logic              accFetch,
  input  logic [ADDR_W-1:0] segBase,
  input  logic [ADDR_W-1:0] segLimit,
  input  logic              segReadable,
  input  logic              segWritable,
  input  logic              segExpDown,
  input  logic              protEn,
  input  logic              pageEn,
  input  logic              longAct,
  input  logic              codeLong64,
  output logic              protFault,
  output logic              needLookup,
  output logic [ADDR_W-1:0] physAddr
);
  segStrobes_t strb;

  segCtrl ctrl_i (
    .accWrite   (accWrite),
    .accFetch   (accFetch),
    .segReadable(segReadable),
    .segWritable(segWritable),
    .segExpDown (segExpDown),
    .protEn     (protEn),
    .pageEn     (pageEn),
    .longAct    (longAct),
    .codeLong64 (codeLong64),
    .strb       (strb)
  );

  segDatapath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) dp_i (
    .linAddr   (linAddr),
    .accSize   (accSize),
    .segBase   (segBase),
    .segLimit  (segLimit),
    .strb      (strb),
    .protFault (protFault),
    .needLookup(needLookup),
    .physAddr  (physAddr)
  );
endmodule

// File: rtl/segLimitChecker_sva.sv
module segLimitChecker_sva #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input logic [ADDR_W-1:0] linAddr,
  input logic [SIZE_W-1:0] accSize,
  input logic              accWrite,
  input logic              accFetch,
  input logic              segWritable,
  input logic              protEn,
  input logic              pageEn,
  input logic              longAct,
  input logic              codeLong64,
  input logic              protFault,
  input logic              needLookup,
  input logic [ADDR_W-1:0] physAddr
);
  logic [SIZE_W-1:0] sizeSeen;
  logic              fetchSeen;

  always_comb begin
    sizeSeen  = accSize;
    fetchSeen = accFetch;
    // R1
    real_mode_pass_chk: assert (protEn || (!protFault && !needLookup && physAddr == linAddr))
      else $error("real mode access altered");
    // R2
    long_skip_chk: assert (!(protEn && longAct && codeLong64) || !protFault)
      else $error("fault raised in 64-bit mode");
    // R3
    write_protect_chk: assert (!(protEn && !(longAct && codeLong64) && accWrite && !segWritable) || protFault)
      else $error("write to read-only segment not caught");
    // R9
    lookup_req_chk: assert (!(protEn && pageEn && !protFault) || (needLookup && physAddr == '0))
      else $error("paged access without lookup");
    // R10
    flat_pass_chk: assert (!(protEn && !pageEn && !protFault) || (!needLookup && physAddr == linAddr))
      else $error("unpaged access not passed through");
    // R11
    fault_mask_chk: assert (!protFault || (!needLookup && physAddr == '0))
      else $error("fault did not mask results");
  end
endmodule

bind segLimitChecker segLimitChecker_sva #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) chk_i (.*);

// File: tb/segLimitChecker_tb_top.sv
module segLimitChecker_tb_top;
  localparam int AW = 5;
  localparam int SW = 2;
  localparam int SPAN = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [AW-1:0] linAddr, segBase, segLimit;
  logic [SW-1:0] accSize;
  logic accWrite, accFetch, segReadable, segWritable, segExpDown;
  logic protEn, pageEn, longAct, codeLong64;
  logic protFault, needLookup;
  logic [AW-1:0] physAddr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  segLimitChecker #(.ADDR_W(AW), .SIZE_W(SW)) dut_i (
    .linAddr(linAddr), .accSize(accSize), .accWrite(accWrite), .accFetch(accFetch),
    .segBase(segBase), .segLimit(segLimit), .segReadable(segReadable),
    .segWritable(segWritable), .segExpDown(segExpDown), .protEn(protEn),
    .pageEn(pageEn), .longAct(longAct), .codeLong64(codeLong64),
    .protFault(protFault), .needLookup(needLookup), .physAddr(physAddr)
  );

  // Independent model; tags: R1 real mode, R2 full long mode, R12 half long mode,
  // R3 write rights, R4 read rights, R5..R8 bound rules, R9/R10 no-fault paths, R11 fault masking.
  task automatic model(output bit f, output bit lk, output int ph, output string tag);
    int a, s, b, l, e;
    bit chk, rightsBad, bnd;
    a = int'(linAddr); s = int'(accSize); b = int'(segBase); l = int'(segLimit);
    e = a + s;
    f = 0; lk = 0; ph = a; tag = "R1";
    if (!protEn) return;
    chk = !(longAct && codeLong64);
    if (!chk) tag = "R2";
    rightsBad = 0; bnd = 0;
    if (chk) begin
      if (accWrite && !segWritable) begin rightsBad = 1; tag = "R3"; end
      else if (!accWrite && !accFetch && !segReadable) begin rightsBad = 1; tag = "R4"; end
      if (!segExpDown) begin
        if (l >= b) begin bnd = e > l; if (!rightsBad) tag = "R5"; end
        else begin bnd = (e > l) && (a < b); if (!rightsBad) tag = "R6"; end
      end else begin
        if (l >= b) begin bnd = (a <= l) && (e >= b); if (!rightsBad) tag = "R7"; end
        else begin bnd = (a <= l) || (e >= b); if (!rightsBad) tag = "R8"; end
      end
      if (longAct != codeLong64) tag = {tag, "/R12"};
    end
    f = rightsBad || bnd;
    if (f) begin ph = 0; lk = 0; tag = {tag, "/R11"}; end
    else if (pageEn) begin lk = 1; ph = 0; tag = {tag, "/R9"}; end
    else begin lk = 0; tag = {tag, "/R10"}; end
  endtask

  task automatic checkNow();
    bit ef, el; int ep; string tg;
    #1;
    model(ef, el, ep, tg);
    checks++;
    if (protFault !== ef || needLookup !== el || int'(physAddr) !== ep) begin
      fails++;
      $display("FAIL %s: addr=%0d size=%0d base=%0d limit=%0d got fault=%0b lookup=%0b phys=%0d expected fault=%0b lookup=%0b phys=%0d",
               tg, linAddr, accSize, segBase, segLimit, protFault, needLookup, physAddr, ef, el, ep);
    end
  endtask

  task automatic setMode(input bit pe, input bit pg, input bit lm, input bit c64);
    protEn = pe; pageEn = pg; longAct = lm; codeLong64 = c64;
  endtask

  initial begin
    linAddr = '0; segBase = '0; segLimit = '0; accSize = '0;
    accWrite = 0; accFetch = 0; segReadable = 0; segWritable = 0; segExpDown = 0;
    setMode(0, 0, 0, 0);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle state: all inputs low gives real-mode pass-through of address 0 (R1)
    checkNow();

    // R5 R6 R7 R8: exhaustive bound sweep, rights allowed, both paging settings
    segReadable = 1; segWritable = 1;
    for (int d = 0; d < 2; d++) begin
      segExpDown = d[0];
      for (int b = 0; b < SPAN; b++)
        for (int l = 0; l < SPAN; l++)
          for (int a = 0; a < SPAN; a++)
            for (int s = 0; s < (1 << SW); s++) begin
              segBase = AW'(b); segLimit = AW'(l); linAddr = AW'(a); accSize = SW'(s);
              setMode(1, s[0] ^ a[0], 0, 0);
              checkNow();
            end
    end

    // R1 R2 R3 R4 R9 R10 R11 R12: every mode / kind / attribute combination
    for (int t = 0; t < 4; t++) begin
      case (t)
        0: begin segBase = 5'd4;  segLimit = 5'd20; linAddr = 5'd10; accSize = 2'd2; end
        1: begin segBase = 5'd4;  segLimit = 5'd20; linAddr = 5'd19; accSize = 2'd3; end
        2: begin segBase = 5'd24; segLimit = 5'd6;  linAddr = 5'd30; accSize = 2'd3; end
        default: begin segBase = 5'd8; segLimit = 5'd16; linAddr = 5'd3; accSize = 2'd1; end
      endcase
      for (int m = 0; m < 512; m++) begin
        setMode(m[0], m[1], m[2], m[3]);
        accWrite = m[4]; accFetch = m[5];
        segReadable = m[6]; segWritable = m[7]; segExpDown = m[8];
        checkNow();
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule